// File: doc/BRIEF.md
# I2C Register Slave with Range-Gated Auto-Increment

This block is the serial front end of a register-mapped peripheral. It takes raw SCL and SDA from the pads and brings each line through a two-flop synchroniser and a glitch filter. From the clean lines it derives START, STOP and repeated START, and then runs a 7-bit-address slave protocol engine. On a match it acknowledges and moves bytes between the bus and an external register file. That register file sits behind a plain pointer / write-data / write-strobe / read-data port, and read data is expected combinationally for the current pointer.

A write transfer carries one register-address byte, which loads the pointer, followed by any number of data bytes. A read transfer uses a repeated START with the read bit set and streams bytes out MSB first until the master answers NACK. The pointer advances by one after each data byte, but only while it lies inside one of a set of parameterised auto-increment windows. Outside those windows, every byte goes to the same register. The general call address is acknowledged, and the bytes that follow it are passed out on a separate strobe without touching the register file. Everything else on the bus is ignored.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, sda_oe_o is 0, reg_addr_o is 0, and no strobe is active.
- R2: A first byte after START whose upper seven bits equal DEV_ADDR (default 7'h2A) is acknowledged. The block asserts sda_oe_o (SDA pulled low) while SCL is high in the ninth clock.
- R3: A first byte that neither matches DEV_ADDR nor equals 8'h00 is not acknowledged. For the rest of that transfer, sda_oe_o stays 0 and no strobe fires.
- R4: In a write (R/W bit 0), the byte after the address loads reg_addr_o. Each following complete byte is acknowledged and produces exactly one reg_we_o pulse, with that byte on reg_wdata_o and the target register on reg_addr_o.
- R5: After each data byte, the pointer advances by one only when its current value lies in an auto-increment window (defaults 8'h00..8'h0F and 8'h20..8'h2F). Otherwise it stays fixed.
- R6: After a repeated START with R/W bit 1, the block shifts out reg_rdata_i for the current pointer, MSB first, with 0 driven as sda_oe_o=1. A master ACK fetches the next byte under the rule of R5. A master NACK releases SDA for the rest of the transfer.
- R7: A first byte of 8'h00 (general call, write) is acknowledged. Each following byte is acknowledged and reported by a gc_we_o pulse with the byte on reg_wdata_o. Neither reg_we_o nor the pointer is affected.
- R8: A STOP or START during a byte abandons it. The partial byte is never written, a STOP returns the block to idle, and a START begins a new address byte.
- R9: Pulses on SCL or SDA shorter than FILT_LEN system clocks (default 4) have no effect on the protocol.
- R10: sda_oe_o is asserted only while the filtered SCL is low. It is asserted only in an acknowledge slot of a byte the block receives, or in the data bits of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr_o | output | AW | Register pointer |
| reg_wdata_o | output | 8 | Byte received for a register or general call |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_re_o | output | 1 | One-cycle strobe when a byte is fetched for a read |
| reg_rdata_i | input | 8 | Register contents at reg_addr_o, combinational |
| gc_we_o | output | 1 | One-cycle strobe for a byte following a general call |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it forms START and STOP. They also assume that every intended level on either line lasts well beyond the synchroniser delay plus FILT_LEN clocks. Under those assumptions, a filtered SCL edge never coincides with a filtered SDA edge. The stimulus keeps within this by using SCL quarter periods of ten system clocks and moving SDA only in the low quarter. Its deliberate pulses last two clocks, half the filter length, so they must vanish rather than produce an edge.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_REG,
    ST_ACK_R,
    ST_WDATA,
    ST_ACK_D,
    ST_GDATA,
    ST_ACK_G,
    ST_TX,
    ST_RACK,
    ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        out_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign line_o = out_q;

  // R9
  filt_settled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> ($past(sync_q[1]) == line_o));
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events #(
  parameter int FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw, filt;
  logic       scl_q, sda_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .line_o (filt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= filt[0];
      sda_q <= filt[1];
    end
  end

  assign scl_o      = filt[0];
  assign sda_o      = filt[1];
  assign scl_rise_o = filt[0] & ~scl_q;
  assign scl_fall_o = ~filt[0] & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = filt[0] & scl_q & sda_q & ~filt[1];
  assign stop_o     = filt[0] & scl_q & ~sda_q & filt[1];
endmodule

// File: rtl/i2c_ai_table.sv
module i2c_ai_table #(
  parameter int                 AW     = 8,
  parameter int                 AI_NUM = 2,
  parameter logic [AI_NUM*AW-1:0] AI_LO = 16'h2000,
  parameter logic [AI_NUM*AW-1:0] AI_HI = 16'h2F0F
) (
  input  logic [AW-1:0] addr_i,
  output logic          ai_o
);
  logic [AI_NUM-1:0] hit;

  for (genvar g = 0; g < AI_NUM; g++) begin : g_rng
    localparam logic [AW-1:0] LO = AI_LO[g*AW +: AW];
    localparam logic [AW-1:0] HI = AI_HI[g*AW +: AW];
    assign hit[g] = ({1'b0, addr_i} >= {1'b0, LO}) && (addr_i <= HI);
  end

  assign ai_o = |hit;
endmodule

// File: rtl/i2c_slv_ctrl.sv
module i2c_slv_ctrl
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         AW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          ai_i,
  input  logic [7:0]    reg_rdata_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [7:0]    reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  output logic          gc_we_o
);
  localparam logic [3:0] FULL = 4'(BYTE_BITS);

  slv_state_e    state_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sh_q, wdata_q;
  logic [AW-1:0] ptr_q;
  logic          oe_q, rw_q, gc_q, ackd_q, we_q, re_q, gcwe_q;
  logic          rx_st, byte_done;

  assign rx_st = (state_q == ST_ADDR) || (state_q == ST_REG) ||
                 (state_q == ST_WDATA) || (state_q == ST_GDATA);
  assign byte_done = scl_fall_i && (cnt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      gc_q    <= 1'b0;
      ackd_q  <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      gcwe_q  <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      re_q   <= 1'b0;
      gcwe_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        if (scl_rise_i && rx_st) begin
          sh_q  <= {sh_q[6:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end
        unique case (state_q)
          ST_ADDR: if (byte_done) begin
            if (sh_q[7:1] == DEV_ADDR) begin
              oe_q <= 1'b1; rw_q <= sh_q[0]; gc_q <= 1'b0; state_q <= ST_ACK_A;
            end else if (sh_q == 8'h00) begin
              oe_q <= 1'b1; rw_q <= 1'b0; gc_q <= 1'b1; state_q <= ST_ACK_A;
            end else begin
              state_q <= ST_SKIP;
            end
          end
          ST_ACK_A: if (scl_fall_i) begin
            cnt_q <= '0;
            if (gc_q) begin
              oe_q <= 1'b0; state_q <= ST_GDATA;
            end else if (rw_q) begin
              sh_q <= reg_rdata_i; oe_q <= ~reg_rdata_i[7]; re_q <= 1'b1; state_q <= ST_TX;
            end else begin
              oe_q <= 1'b0; state_q <= ST_REG;
            end
          end
          ST_REG: if (byte_done) begin
            ptr_q <= AW'(sh_q); oe_q <= 1'b1; state_q <= ST_ACK_R;
          end
          ST_WDATA: if (byte_done) begin
            wdata_q <= sh_q; we_q <= 1'b1; oe_q <= 1'b1; state_q <= ST_ACK_D;
          end
          ST_GDATA: if (byte_done) begin
            wdata_q <= sh_q; gcwe_q <= 1'b1; oe_q <= 1'b1; state_q <= ST_ACK_G;
          end
          ST_ACK_R, ST_ACK_D, ST_ACK_G: if (scl_fall_i) begin
            oe_q  <= 1'b0;
            cnt_q <= '0;
            if (state_q == ST_ACK_D && ai_i) ptr_q <= ptr_q + AW'(1);
            state_q <= (state_q == ST_ACK_G) ? ST_GDATA : ST_WDATA;
          end
          ST_TX: begin
            if (scl_rise_i) cnt_q <= cnt_q + 4'd1;
            if (scl_fall_i) begin
              if (cnt_q == FULL) begin
                oe_q <= 1'b0; state_q <= ST_RACK;
              end else begin
                sh_q <= {sh_q[6:0], 1'b0}; oe_q <= ~sh_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              ackd_q <= ~sda_i;
              if (!sda_i && ai_i) ptr_q <= ptr_q + AW'(1);
            end
            if (scl_fall_i) begin
              if (ackd_q) begin
                cnt_q <= '0; sh_q <= reg_rdata_i; oe_q <= ~reg_rdata_i[7];
                re_q <= 1'b1; state_q <= ST_TX;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;
  assign gc_we_o     = gcwe_q;

  // R10
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
  // R3
  quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP || state_q == ST_IDLE) |-> !sda_oe_o);
  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, gc_we_o, reg_re_o}));
  // R5
  ptr_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_o != $past(reg_addr_o)) |-> $past(scl_rise_i || scl_fall_i));
  // R8
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE && !sda_oe_o));
  // R8
  start_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (state_q == ST_ADDR && cnt_q == 4'd0));
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0]           DEV_ADDR = 7'h2A,
  parameter int                   AW       = 8,
  parameter int                   FILT_LEN = 4,
  parameter int                   AI_NUM   = 2,
  parameter logic [AI_NUM*AW-1:0] AI_LO    = 16'h2000,
  parameter logic [AI_NUM*AW-1:0] AI_HI    = 16'h2F0F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [7:0]    reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  input  logic [7:0]    reg_rdata_i,
  output logic          gc_we_o
);
  logic scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c, ai;

  i2c_bus_events #(.FILT_LEN(FILT_LEN)) u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_f),
    .sda_o      (sda_f),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_ai_table #(.AW(AW), .AI_NUM(AI_NUM), .AI_LO(AI_LO), .AI_HI(AI_HI)) u_ai (
    .addr_i (reg_addr_o),
    .ai_o   (ai)
  );

  i2c_slv_ctrl #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (scl_f),
    .sda_i       (sda_f),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_c),
    .stop_i      (stop_c),
    .ai_i        (ai),
    .reg_rdata_i (reg_rdata_i),
    .sda_oe_o    (sda_oe_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o),
    .reg_re_o    (reg_re_o),
    .gc_we_o     (gc_we_o)
  );
endmodule

// File: tb/i2c_reg_slave_bench.sv
module i2c_reg_slave_bench;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, scl_gl = 1'b0, sda_gl = 1'b0;
  logic sda_oe, we, re, gcwe;
  logic [7:0] raddr, wdata, rdata;
  wire scl_w = scl_m & ~scl_gl;
  wire sda_w = sda_m & ~sda_gl & ~sda_oe;

  i2c_reg_slave u_i2c_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .sda_oe_o(sda_oe), .reg_addr_o(raddr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata), .gc_we_o(gcwe)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic bit ai_ok(input logic [7:0] a);
    return (a <= 8'h0F) || (a >= 8'h20 && a <= 8'h2F);
  endfunction

  // register file behind the slave
  logic [7:0] mem [256];
  int we_cnt = 0, gc_cnt = 0, oe_cnt = 0, viol = 0;
  logic [7:0] gc_log [4];
  logic oe_p = 1'b0;
  assign rdata = mem[raddr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else begin
      if (we) begin mem[raddr] <= wdata; we_cnt <= we_cnt + 1; end
      if (gcwe) begin
        if (gc_cnt < 4) gc_log[gc_cnt] <= wdata;
        gc_cnt <= gc_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    oe_p <= sda_oe;
    if (rst_n && sda_oe) oe_cnt <= oe_cnt + 1;
    if (rst_n && sda_oe != oe_p && scl_w) viol <= viol + 1;
  end

  logic [7:0] exp_mem [256];
  logic [7:0] ptr_m;
  logic [7:0] wbuf [8];
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic put_bit(input bit b, input bit g);
    sda_m = b; wq(); scl_m = 1'b1; wq();
    if (g) begin
      scl_gl = 1'b1; repeat (2) @(negedge clk); scl_gl = 1'b0;
      repeat (3) @(negedge clk);
      if (b) begin sda_gl = 1'b1; repeat (2) @(negedge clk); sda_gl = 1'b0; end
    end
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_w; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_bits(input logic [7:0] d, input int nb);
    for (int i = 7; i > 7 - nb; i--) put_bit(d[i], 1'b0);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit g, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(d[i], g);
    get_bit(a);
    ack = !a;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit mack);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!mack, 1'b0);
  endtask

  task automatic wr_txn(input logic [7:0] rg, input int n, input bit g);
    bit ack;
    i2c_start();
    send_byte({DEV, 1'b0}, 1'b0, ack);
    chk(ack, "R2 address ack", ack, 1);
    send_byte(rg, 1'b0, ack);
    chk(ack, "R4 register byte ack", ack, 1);
    ptr_m = rg;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], g, ack);
      chk(ack, "R4 data ack", ack, 1);
      exp_mem[ptr_m] = wbuf[i];
      if (ai_ok(ptr_m)) ptr_m = ptr_m + 8'd1;
    end
    i2c_stop();
  endtask

  task automatic rd_txn(input logic [7:0] rg, input int n);
    bit ack;
    logic [7:0] d;
    i2c_start();
    send_byte({DEV, 1'b0}, 1'b0, ack);
    send_byte(rg, 1'b0, ack);
    ptr_m = rg;
    i2c_start();
    send_byte({DEV, 1'b1}, 1'b0, ack);
    chk(ack, "R2 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      chk(d == exp_mem[ptr_m], "R6 read data", d, exp_mem[ptr_m]);
      if (i != n - 1 && ai_ok(ptr_m)) ptr_m = ptr_m + 8'd1;
    end
    chk(!sda_oe, "R6 released after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  initial begin
    bit ack;
    int w0, o0, g0, bad;
    logic [7:0] rg;
    int n;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1
    chk(!sda_oe && raddr == 8'h00 && !we && !re && !gcwe, "R1 reset state",
        {sda_oe, we, re, gcwe, raddr}, 0);

    // R7 general call
    i2c_start();
    send_byte(8'h00, 1'b0, ack);
    chk(ack, "R7 general call ack", ack, 1);
    send_byte(8'h06, 1'b0, ack);
    send_byte(8'h77, 1'b0, ack);
    chk(ack, "R7 general call data ack", ack, 1);
    i2c_stop();
    chk(gc_cnt == 2 && we_cnt == 0, "R7 strobe counts", gc_cnt * 16 + we_cnt, 32);
    chk(gc_log[0] == 8'h06 && gc_log[1] == 8'h77, "R7 general call bytes",
        {gc_log[0], gc_log[1]}, 16'h0677);
    chk(raddr == 8'h00, "R7 pointer untouched", raddr, 0);

    // R3 foreign address
    o0 = oe_cnt; w0 = we_cnt;
    i2c_start();
    send_byte({7'h2B, 1'b0}, 1'b0, ack);
    chk(!ack, "R3 no ack foreign", ack, 0);
    send_byte(8'h12, 1'b0, ack);
    send_byte(8'h34, 1'b0, ack);
    i2c_stop();
    chk(oe_cnt == o0 && we_cnt == w0, "R3 SDA untouched", oe_cnt - o0, 0);

    // R4 R5 window end: 0x0F increments, 0x10 fixed
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    wr_txn(8'h0F, 3, 1'b0);
    repeat (4) @(negedge clk);
    chk(mem[8'h0F] == 8'hA1 && mem[8'h10] == 8'hC3 && mem[8'h11] == exp_mem[8'h11],
        "R5 window boundary", {mem[8'h0F], mem[8'h10]}, 16'hA1C3);
    // R5 outside window stays fixed
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_txn(8'h30, 2, 1'b0);
    repeat (4) @(negedge clk);
    chk(mem[8'h30] == 8'h22 && mem[8'h31] == exp_mem[8'h31], "R5 fixed pointer",
        mem[8'h30], 8'h22);
    rd_txn(8'h0E, 3);

    // R8 abort by STOP mid byte
    w0 = we_cnt;
    i2c_start();
    send_byte({DEV, 1'b0}, 1'b0, ack);
    send_byte(8'h40, 1'b0, ack);
    send_bits(8'h99, 4);
    i2c_stop();
    chk(we_cnt == w0 && mem[8'h40] == exp_mem[8'h40], "R8 stop mid byte",
        mem[8'h40], exp_mem[8'h40]);
    // R8 abort by START mid byte
    i2c_start();
    send_byte({DEV, 1'b0}, 1'b0, ack);
    send_byte(8'h41, 1'b0, ack);
    send_bits(8'h66, 3);
    wbuf[0] = 8'h5A;
    wr_txn(8'h42, 1, 1'b0);
    repeat (4) @(negedge clk);
    chk(mem[8'h41] == exp_mem[8'h41] && mem[8'h42] == 8'h5A, "R8 start mid byte",
        {mem[8'h41], mem[8'h42]}, {exp_mem[8'h41], 8'h5A});

    // R9 short pulses on both lines
    wbuf[0] = 8'hFF; wbuf[1] = 8'h3C;
    wr_txn(8'h25, 2, 1'b1);
    repeat (4) @(negedge clk);
    chk(mem[8'h25] == 8'hFF && mem[8'h26] == 8'h3C, "R9 glitches ignored",
        {mem[8'h25], mem[8'h26]}, 16'hFF3C);

    // random mix
    for (int t = 0; t < 20; t++) begin
      rg = 8'($urandom % 64);
      n = 1 + int'($urandom % 4);
      if ($urandom % 2 == 0) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        wr_txn(rg, n, 1'b0);
      end else begin
        rd_txn(rg, n);
      end
    end

    repeat (10) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, "R4 register image", bad, 0);
    // R10
    chk(viol == 0, "R10 SDA moved with SCL high", viol, 0);
    g0 = gc_cnt;
    chk(g0 == 2, "R7 no stray general call strobes", g0, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule